// File: doc/BRIEF.md
# Protected Asynchronous SRAM Array Controller

This block is a byte-wide static memory behind the classic asynchronous three-strobe interface: active-low chip select, output enable and write strobe. It runs all three strobes and the protect input through one register stage on the system clock. It then works out reads and write windows from the registered copies, so the design has no combinational loop and no latch. The data bus is split into an input byte, an output byte and a drive-enable. An external tri-state buffer built from `dout` and `dout_en` forms the real pin.

A write window exists only while both chip select and write strobe are sampled low. It therefore opens on whichever of the two falls later and closes on whichever rises first. The byte stored is the last one sampled while the window was open. It goes to the address captured when the window opened. The protect input masks every strobe: while it is high the bus is not driven, nothing is stored, and a window that protect interrupts is dropped. If the address moves while a window is open, an error pulse is raised and that write is discarded. The strobe interface carries no flow control, so the stream handshake style does not apply here. The pins remain plain levels.

The depth is set by `ADDR_W`. The default of 11 keeps the array small. Setting `ADDR_W = 15` gives the full 32,768 bytes.

Top module: `prot_sram_ctl`

## Requirements
- R1: The array holds 2**ADDR_W bytes, and each address keeps its own value: data written to one address reads back unchanged after writes to other addresses, including address 0 and the highest address.
- R2: When chip select and output enable are sampled low, the write strobe is sampled high and protect is sampled low, then `dout_en` is 1 from the next clock edge and `dout` carries the byte at the sampled address.
- R3: When the write strobe is sampled low, `dout_en` is 0 from the next edge, even with chip select and output enable low.
- R4: A write window exists only in cycles where chip select and write strobe are both sampled low. It opens on the later falling strobe and closes on the earlier rising one. A write-strobe pulse alone or a chip-select pulse alone stores nothing.
- R5: When a window closes, the last data byte sampled inside it is stored at the address sampled in the window's first cycle.
- R6: When protect is sampled high, `dout_en` and `dout` are 0 from the next edge and all strobes are ignored. A window that closes while protect is high, including one that protect cuts short, stores nothing.
- R7: If the sampled address differs from the window's opening address while the window stays open, `addr_err` is 1 for one cycle starting one edge after that sample, and the whole write is discarded.
- R8: A read of the address being committed, in the same cycle the window closes, returns the newly committed byte.
- R9: During and straight after reset, `dout_en`, `dout` and `addr_err` are 0 and no window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| protect | input | 1 | Write protect; masks every input when high |
| dout | output | DATA_W | Read data toward the bus (0 when not driving) |
| dout_en | output | 1 | Bus drive enable |
| addr_err | output | 1 | One-cycle pulse: address moved inside a write window |

## Verification
A write can close in the same cycle that a read of the same address begins. This happens when the write strobe rises while chip select and output enable stay low. The bench provokes it with exactly that strobe sequence and judges it against a behavioural model that applies the commit before it evaluates the read, so the new byte must appear in that cycle. A second overlap is protect rising while a window is open: the bench raises protect with the strobes still low and then reads the location back to confirm that the old value survives.

// File: rtl/psram_pkg.sv
package psram_pkg;
  // Strobes in active-high form after sampling and protect masking.
  typedef struct packed {
    logic ce;
    logic oe;
    logic we;
  } psram_strb_t;
endpackage

// File: rtl/psram_sampler.sv
module psram_sampler
  import psram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              protect,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output psram_strb_t       act,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_din,
  output logic              s_prot
);
  psram_strb_t raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      s_prot <= 1'b0;
      s_addr <= '0;
      s_din  <= '0;
    end else begin
      raw_q.ce <= ~ce_n;
      raw_q.oe <= ~oe_n;
      raw_q.we <= ~we_n;
      s_prot   <= protect;
      s_addr   <= addr;
      s_din    <= din;
    end
  end

  // Protect turns every strobe into don't-care.
  always_comb begin
    act = s_prot ? '0 : raw_q;
  end
endmodule

// File: rtl/psram_wwin.sv
module psram_wwin #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              s_prot,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_din,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              addr_err
);
  logic win, win_q, bad_q, opening, moved;

  assign win     = sel & wr;
  assign opening = win & ~win_q;
  assign moved   = win & win_q & (s_addr != wr_addr);
  // Commit on the first cycle after the window ends, unless aborted.
  assign wr_en   = win_q & ~win & ~bad_q & ~s_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= 1'b0;
      bad_q    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      addr_err <= 1'b0;
    end else begin
      win_q    <= win;
      addr_err <= moved;
      if (opening) begin
        wr_addr <= s_addr;
        bad_q   <= 1'b0;
      end else if (moved) begin
        bad_q <= 1'b1;
      end
      if (win) wr_data <= s_din;
    end
  end
endmodule

// File: rtl/psram_store.sv
module psram_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/prot_sram_ctl.sv
module prot_sram_ctl
  import psram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              protect,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              addr_err
);
  psram_strb_t       act;
  logic [ADDR_W-1:0] s_addr, wr_addr;
  logic [DATA_W-1:0] s_din, wr_data, cell_q;
  logic              s_prot, wr_en, rd, fwd;

  psram_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .protect(protect), .addr(addr), .din(din), .act(act),
    .s_addr(s_addr), .s_din(s_din), .s_prot(s_prot)
  );

  psram_wwin #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_win (
    .clk(clk), .rst_n(rst_n), .sel(act.ce), .wr(act.we), .s_prot(s_prot),
    .s_addr(s_addr), .s_din(s_din), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .addr_err(addr_err)
  );

  psram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(s_addr), .rd_data(cell_q)
  );

  // Write strobe wins over output enable.
  assign rd      = act.ce & act.oe & ~act.we;
  // A commit still in flight is forwarded to a read of the same byte.
  assign fwd     = wr_en & (wr_addr == s_addr);
  assign dout_en = rd;
  assign dout    = rd ? (fwd ? wr_data : cell_q) : '0;
endmodule

// File: rtl/psram_chk.sv
module psram_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              protect,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              addr_err,
  input logic              wr_en
);
  assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && we_n && !protect) |=> dout_en);

  assert_we_blocks_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !protect) |=> !dout_en);

  assert_protect_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    protect |=> (!dout_en && dout == '0));

  assert_no_store_protected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$past(protect));

  assert_err_needs_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_n || ce_n || protect) |=> ##1 !addr_err);
endmodule

bind prot_sram_ctl psram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .protect(protect), .dout(dout), .dout_en(dout_en), .addr_err(addr_err),
  .wr_en(wr_en)
);

// File: tb/sim_prot_sram_ctl.sv
`timescale 1ns/1ps
module sim_prot_sram_ctl;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int MAXA = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, protect = 1'b0;
  logic [DW-1:0] dout;
  logic dout_en, addr_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prot_sram_ctl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .protect(protect), .dout(dout),
    .dout_en(dout_en), .addr_err(addr_err)
  );

  // Behavioural reference model
  logic [DW-1:0] mref [int];
  bit in_win = 0, bad = 0, err_pend = 0;
  int wa = 0;
  logic [DW-1:0] wd = '0;
  bit e_en = 0, e_err = 0;
  int e_addr = 0;
  string e_tag = "R9";

  always @(posedge clk) begin
    if (!rst_n) begin
      in_win = 0; bad = 0; err_pend = 0; e_en = 0; e_err = 0; e_tag = "R9";
    end else begin
      bit act;
      act = !ce_n && !we_n && !protect;
      e_err = err_pend;
      err_pend = 0;
      if (in_win && !act && !bad && !protect) mref[wa] = wd;
      if (act) begin
        if (!in_win) begin
          wa = int'(addr); bad = 0;
        end else if (int'(addr) != wa) begin
          bad = 1; err_pend = 1;
        end
        wd = din;
      end
      in_win = act;
      e_en = !ce_n && !oe_n && we_n && !protect;
      e_addr = int'(addr);
      e_tag = protect ? "R6" : (!we_n ? "R3" : "R2");
    end
  end

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #5;
    if (!done) begin
      chk(dout_en == e_en, e_tag, dout_en, e_en);
      chk(addr_err == e_err, "R7", addr_err, e_err);
      if (e_en && mref.exists(e_addr))
        chk(dout == mref[e_addr], "R2", dout, mref[e_addr]);
      else if (!e_en)
        chk(dout == '0, e_tag, dout, 0);
    end
  end

  task automatic step(input bit c, input bit o, input bit w, input bit p,
                      input int a, input int d);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; protect = p;
    addr = AW'(a); din = DW'(d);
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    step(1, 1, 1, 0, 0, 0);
  endtask

  task automatic wr(input int a, input int d);
    step(0, 1, 1, 0, a, d);
    step(0, 1, 0, 0, a, d);
    step(0, 1, 0, 0, a, d);
    step(0, 1, 1, 0, a, d);
    idle();
  endtask

  task automatic rd_chk(input int a, input int exp_v, input string req);
    step(0, 0, 1, 0, a, 0);
    chk(dout_en == 1'b1, req, dout_en, 1);
    chk(dout == DW'(exp_v), req, dout, exp_v);
    idle();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk(dout_en == 1'b0, "R9", dout_en, 0);
    chk(addr_err == 1'b0, "R9", addr_err, 0);
    chk(dout == '0, "R9", dout, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    chk(dout_en == 1'b0 && addr_err == 1'b0, "R9", dout_en, 0);

    // R1: independent locations, edges of the address range
    wr(0, 8'hA1);
    wr(MAXA, 8'h5E);
    for (int i = 1; i < 12; i++) wr(i * 97, (i * 37) ^ 8'h5A);
    rd_chk(0, 8'hA1, "R1");
    rd_chk(MAXA, 8'h5E, "R1");
    for (int i = 1; i < 12; i++) rd_chk(i * 97, ((i * 37) ^ 8'h5A) & 8'hFF, "R1");

    // R5: last byte inside the window is kept
    step(0, 1, 1, 0, 40, 8'h11);
    step(0, 1, 0, 0, 40, 8'h22);
    step(0, 1, 0, 0, 40, 8'h33);
    step(0, 1, 1, 0, 40, 8'h44);
    idle();
    rd_chk(40, 8'h33, "R5");

    // R4: write strobe falls first, chip select later; chip select rises first
    step(1, 1, 0, 0, 41, 8'h10);
    step(0, 1, 0, 0, 41, 8'h6C);
    step(1, 1, 0, 0, 41, 8'h77);
    step(1, 1, 1, 0, 41, 8'h77);
    rd_chk(41, 8'h6C, "R4");
    // R4: lone pulses store nothing
    step(1, 1, 0, 0, 41, 8'hEE);
    step(1, 1, 1, 0, 41, 8'hEE);
    step(0, 1, 1, 0, 41, 8'hEE);
    idle();
    rd_chk(41, 8'h6C, "R4");

    // R3 and R8: read held across a write, same-cycle commit forwarding
    wr(7, 8'h01);
    step(0, 0, 1, 0, 7, 8'h00);
    step(0, 0, 0, 0, 7, 8'h99);
    chk(dout_en == 1'b0, "R3", dout_en, 0);
    step(0, 0, 1, 0, 7, 8'h00);
    chk(dout_en == 1'b1, "R8", dout_en, 1);
    chk(dout == 8'h99, "R8", dout, 8'h99);
    idle();

    // R2: plain read
    rd_chk(7, 8'h99, "R2");

    // R6: protect blocks read, write, and cuts an open window
    step(0, 0, 1, 1, 7, 0);
    chk(dout_en == 1'b0, "R6", dout_en, 0);
    chk(dout == '0, "R6", dout, 0);
    step(0, 1, 0, 1, 7, 8'hCC);
    step(0, 1, 1, 1, 7, 8'hCC);
    idle();
    rd_chk(7, 8'h99, "R6");
    step(0, 1, 0, 0, 7, 8'hDD);
    step(0, 1, 0, 1, 7, 8'hDD);
    step(1, 1, 1, 1, 7, 8'hDD);
    idle();
    rd_chk(7, 8'h99, "R6");

    // R7: address moves inside a window
    wr(20, 8'h20);
    wr(21, 8'h21);
    step(0, 1, 0, 0, 20, 8'hF0);
    step(0, 1, 0, 0, 21, 8'hF1);
    chk(addr_err == 1'b0, "R7", addr_err, 0);
    step(0, 1, 0, 0, 21, 8'hF1);
    chk(addr_err == 1'b1, "R7", addr_err, 1);
    step(1, 1, 1, 0, 21, 8'hF1);
    idle();
    chk(addr_err == 1'b0, "R7", addr_err, 0);
    rd_chk(20, 8'h20, "R7");
    rd_chk(21, 8'h21, "R7");

    repeat (2) idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule